// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block puts a clocked request/response port in front of an external asynchronous static RAM of 2^20 bytes. A client offers a request by raising `req_valid` with a read/write flag, a 20-bit address and a write byte. The block takes it when `req_ready` is high. It then runs the memory's active-low chip enable, write enable and output enable, the address lines and the bidirectional data bus through a fixed sequence of clock states. When the access completes, it returns a one-cycle `rsp_valid` pulse, which carries the read byte on reads.

Every nanosecond constraint of the memory is a parameter counted in clock cycles. The defaults suit a 100 MHz clock: 10000 cycles of power-up wait (100 us), two read wait cycles, one address/data setup cycle before write enable falls, one write-enable-low cycle and one bus turnaround cycle.

The controller drives the data bus only while a write is in progress. When a read directly follows a write, it inserts an idle gap in which nobody drives the bus. Requests may be issued back to back, because a new one is taken in the cycle that completes the previous one.

Top module: `sram_bridge`

## Requirements
- R1: From reset, `req_ready` and `rsp_valid` are low for exactly PWRUP_CYC rising clock edges. Over that window `mem_ce_n`, `mem_we_n` and `mem_oe_n` stay high and `mem_dq_oe` stays low, and any request offered is ignored. `req_ready` is high after edge PWRUP_CYC. A reset during an access returns the block to this state at once.
- R2: A read holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for RD_WAIT cycles with the latched address. The next cycle has `rsp_valid`=1 with `rsp_rdata` equal to `mem_dq_in` as sampled in the last wait cycle. `rsp_valid` rises RD_WAIT+1 cycles after the accepting edge (plus TURN_CYC when R5 applies).
- R3: A write runs in three phases. First comes SETUP_CYC cycles with `mem_ce_n`=0 and `mem_we_n`=1. Then come WE_CYC cycles with `mem_we_n`=0. Last is one completion cycle with `mem_we_n`=1, `mem_ce_n`=0 and `rsp_valid`=1. `mem_dq_oe` is 1 in all of them and `mem_oe_n` is 1 in all of them. The latency is SETUP_CYC+WE_CYC+1 cycles.
- R4: `mem_dq_oe` is 1 only during the cycles of a write, and never while `mem_oe_n` is 0.
- R5: A read accepted in a write's completion cycle first spends TURN_CYC cycles with all three strobes high and `mem_dq_oe`=0. A read accepted from idle goes straight to the access.
- R6: `req_ready` is high only when idle and in the completion cycle of an access, and `mem_we_n` and `mem_oe_n` are high in those cycles. A request is taken on an edge where `req_valid` and `req_ready` are both 1.
- R7: The operation, address and write byte are latched at acceptance. `mem_addr` equals the latched address whenever `mem_ce_n` is 0, and changes on the request inputs after acceptance have no effect on the access.
- R8: `mem_we_n` and `mem_oe_n` are never low in the same cycle.
- R9: `mem_we_n` is low only while `mem_ce_n` is low. In the cycle `mem_we_n` rises, `mem_addr` and `mem_dq_out` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Request can be taken this cycle |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read byte, valid with `rsp_valid` after a read |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 20 | Memory address lines |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | 1 = controller drives the data bus |
| mem_dq_in | input | 8 | Byte sampled from the data bus |

## Verification
A wrong state or counter value shows up at the strobes in the very cycle it happens. It appears as a strobe pattern that does not match the expected phase, an `rsp_valid` that arrives a cycle early or late, or a bus that has just been driven while output enable falls. The bench therefore checks the three strobes, the address and the bus enable against the phase it expects in every cycle of every access. A capture taken in the wrong cycle or from a stale address surfaces one cycle later as a wrong `rsp_rdata`. A lost write surfaces at the next read of that address.

// File: rtl/sram_bridge.sv
module sram_bridge #(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 8,
  parameter int PWRUP_CYC = 10000,
  parameter int RD_WAIT   = 2,
  parameter int SETUP_CYC = 1,
  parameter int WE_CYC    = 1,
  parameter int TURN_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAXC  = max2(max2(PWRUP_CYC, RD_WAIT), max2(max2(SETUP_CYC, WE_CYC), TURN_CYC));
  localparam int CNT_W = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    S_PWR, S_IDLE, S_RD_ACC, S_RD_CAP, S_WR_SET, S_WR_PUL, S_WR_REL, S_TURN
  } state_t;

  state_t            state, state_nxt;
  logic [CNT_W-1:0]  cnt, lim_m1;
  logic              cnt_last, accept;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdat_q, rdat_q;

  assign req_ready  = (state == S_IDLE) || (state == S_RD_CAP) || (state == S_WR_REL);
  assign accept     = req_valid && req_ready;
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdat_q;
  assign rsp_rdata  = rdat_q;

  always_comb begin
    case (state)
      S_PWR:    lim_m1 = CNT_W'(PWRUP_CYC - 1);
      S_RD_ACC: lim_m1 = CNT_W'(RD_WAIT - 1);
      S_WR_SET: lim_m1 = CNT_W'(SETUP_CYC - 1);
      S_WR_PUL: lim_m1 = CNT_W'(WE_CYC - 1);
      S_TURN:   lim_m1 = CNT_W'(TURN_CYC - 1);
      default:  lim_m1 = '0;
    endcase
  end

  assign cnt_last = (cnt == lim_m1);

  always_comb begin
    state_nxt = state;
    case (state)
      S_PWR:    if (cnt_last) state_nxt = S_IDLE;
      S_IDLE, S_RD_CAP, S_WR_REL: begin
        if (!accept)        state_nxt = S_IDLE;
        else if (req_write) state_nxt = S_WR_SET;
        else                state_nxt = (state == S_WR_REL) ? S_TURN : S_RD_ACC;
      end
      S_RD_ACC: if (cnt_last) state_nxt = S_RD_CAP;
      S_WR_SET: if (cnt_last) state_nxt = S_WR_PUL;
      S_WR_PUL: if (cnt_last) state_nxt = S_WR_REL;
      S_TURN:   if (cnt_last) state_nxt = S_RD_ACC;
      default:  state_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_PWR;
      cnt       <= '0;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      state <= state_nxt;
      if (state_nxt != state) cnt <= '0;
      else if (!cnt_last)     cnt <= cnt + 1'b1;
      mem_ce_n  <= !(state_nxt inside {S_RD_ACC, S_WR_SET, S_WR_PUL, S_WR_REL});
      mem_oe_n  <= !(state_nxt == S_RD_ACC);
      mem_we_n  <= !(state_nxt == S_WR_PUL);
      mem_dq_oe <= state_nxt inside {S_WR_SET, S_WR_PUL, S_WR_REL};
      rsp_valid <= state_nxt inside {S_RD_CAP, S_WR_REL};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
    end else begin
      if (accept) begin
        addr_q <= req_addr;
        wdat_q <= req_wdata;
      end
      if (state == S_RD_ACC && cnt_last) rdat_q <= mem_dq_in;
    end
  end

endmodule

// File: rtl/sram_bridge_chk.sv
module sram_bridge_chk #(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 8,
  parameter int PWRUP_CYC = 10000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);

  localparam int PW = $clog2(PWRUP_CYC + 1);
  localparam logic [PW-1:0] PLIM = PW'(PWRUP_CYC);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pcnt <= '0;
    else if (pcnt != PLIM) pcnt <= pcnt + 1'b1;
  end

  // R1
  pwrup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pcnt != PLIM) |-> (!req_ready && !rsp_valid && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  // R2
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R3
  we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(!mem_ce_n) && $past(mem_dq_oe)));

  // R4
  dq_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R5
  turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  // R6
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_we_n && mem_oe_n));

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  // R9
  we_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_out) && !mem_ce_n));

endmodule

bind sram_bridge sram_bridge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PWRUP_CYC(PWRUP_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_bridge_tb.sv
module sram_bridge_tb;
  localparam int PWRUP = 20;
  localparam int RDW   = 2;
  localparam int SETUP = 1;
  localparam int WEC   = 1;
  localparam int TURN  = 1;
  localparam int NVEC  = 10;

  // {write, address, write byte or expected read byte}
  localparam logic [28:0] VEC [NVEC] = '{
    {1'b1, 20'h00010, 8'h3C}, {1'b1, 20'hFFFFF, 8'hC3},
    {1'b0, 20'h00010, 8'h3C}, {1'b0, 20'hFFFFF, 8'hC3},
    {1'b1, 20'h00020, 8'h5A}, {1'b1, 20'h00030, 8'hA5},
    {1'b0, 20'h00030, 8'hA5}, {1'b1, 20'h00010, 8'hE1},
    {1'b0, 20'h00010, 8'hE1}, {1'b0, 20'h00020, 8'h5A}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  rsp_rdata, mem_dq_out, mem_dq_in;
  logic [19:0] mem_addr;
  int checks = 0, errors = 0;
  int cont_cnt = 0, gap_cnt = 0, excl_cnt = 0;
  logic prev_oe = 1'b0;

  always #4 clk = ~clk;

  sram_bridge #(.ADDR_W(20), .DATA_W(8), .PWRUP_CYC(PWRUP), .RD_WAIT(RDW),
                .SETUP_CYC(SETUP), .WE_CYC(WEC), .TURN_CYC(TURN)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  // memory model: low address byte selects a slot, full address is the tag
  logic [7:0]  m_data [256];
  logic [19:0] m_tag  [256];
  logic        m_ok   [256];
  initial for (int i = 0; i < 256; i++) m_ok[i] = 1'b0;

  always @(posedge mem_we_n)
    if (rst_n && mem_ce_n === 1'b0) begin
      m_data[mem_addr[7:0]] = mem_dq_out;
      m_tag[mem_addr[7:0]]  = mem_addr;
      m_ok[mem_addr[7:0]]   = 1'b1;
    end

  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ?
    ((m_ok[mem_addr[7:0]] && m_tag[mem_addr[7:0]] == mem_addr) ? m_data[mem_addr[7:0]] : 8'h96) : 8'hzz;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_oe_n && mem_dq_oe) cont_cnt++;
      if (!mem_oe_n && prev_oe)   gap_cnt++;
      if (!mem_oe_n && !mem_we_n) excl_cnt++;
    end
    prev_oe = mem_dq_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic w, input logic [19:0] a, input logic [7:0] d, input int turn);
    int n, lat;
    logic bad_ctl, bad_adr, bad_rdy;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = ~w; req_addr = ~a; req_wdata = ~d;
    n = 1; bad_ctl = 0; bad_adr = 0; bad_rdy = 0;
    while (!rsp_valid && n < 64) begin
      if (w) begin
        if (mem_ce_n || !mem_oe_n || !mem_dq_oe || (mem_we_n != !(n > SETUP && n <= SETUP + WEC)))
          bad_ctl = 1;
        if (mem_dq_out != d) bad_adr = 1;
      end else if (n <= turn) begin
        if (!mem_ce_n || !mem_oe_n || !mem_we_n || mem_dq_oe) bad_ctl = 1;
      end else begin
        if (mem_ce_n || mem_oe_n || !mem_we_n || mem_dq_oe) bad_ctl = 1;
      end
      if (!mem_ce_n && mem_addr != a) bad_adr = 1;
      if (req_ready) bad_rdy = 1;
      @(negedge clk); n++;
    end
    lat = w ? SETUP + WEC + 1 : RDW + 1 + turn;
    chk(n == lat, w ? "R3 latency" : "R2 R5 latency", n, lat);
    chk(!bad_ctl, w ? "R3 strobes" : "R2 R5 strobes", bad_ctl, 0);
    chk(!bad_adr, "R7 latched address/data", bad_adr, 0);
    chk(!bad_rdy, "R6 ready low during access", bad_rdy, 0);
    if (w) chk(mem_we_n && !mem_ce_n && mem_dq_oe && mem_addr == a && mem_dq_out == d,
               "R9 release hold", {mem_we_n, mem_ce_n, mem_dq_oe}, 3'b101);
    else   chk(rsp_rdata == d && mem_oe_n, "R2 read data", rsp_rdata, d);
    chk(req_ready, "R6 ready in completion cycle", req_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic bad, prev_w;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h00099; req_wdata = 8'h11;
    repeat (3) @(negedge clk);
    chk(!req_ready && !rsp_valid && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe,
        "R1 reset state", {req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 6'b001110);
    rst_n = 1'b1;
    n = 0; bad = 0;
    while (!req_ready && n < 1000) begin
      if (!mem_ce_n || !mem_we_n || !mem_oe_n || mem_dq_oe || rsp_valid) bad = 1;
      @(negedge clk); n++;
      if (n == PWRUP - 2) req_valid = 1'b0;
    end
    chk(n == PWRUP, "R1 power-up length", n, PWRUP);
    chk(!bad, "R1 request ignored in power-up", bad, 0);

    prev_w = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      run_op(VEC[i][28], VEC[i][27:8], VEC[i][7:0], (!VEC[i][28] && prev_w) ? TURN : 0);
      prev_w = VEC[i][28];
    end

    run_op(1'b1, 20'h00050, 8'h77, 0);
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready, "R4 R6 idle bus",
        {mem_ce_n, mem_dq_oe}, 2'b10);
    run_op(1'b0, 20'h00050, 8'h77, 0);

    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h00060; req_wdata = 8'h42;
    @(negedge clk);
    req_valid = 1'b0;
    while (mem_we_n) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(mem_we_n && mem_ce_n && !req_ready && !mem_dq_oe, "R1 reset mid-write",
        {mem_we_n, mem_ce_n, req_ready}, 3'b110);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    while (!req_ready && n < 1000) begin @(negedge clk); n++; end
    chk(n == PWRUP, "R1 power-up after reset", n, PWRUP);
    run_op(1'b0, 20'h00020, 8'h5A, 0);

    chk(cont_cnt == 0, "R4 no bus contention", cont_cnt, 0);
    chk(gap_cnt == 0, "R5 turnaround gap", gap_cnt, 0);
    chk(excl_cnt == 0, "R8 strobe exclusion", excl_cnt, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule